// File: doc/BRIEF.md
# Condition-Field Register Bank Selector

This block sits between instruction decode and register-file access in a core that can run either as a dynamically scheduled in-order machine or in a statically scheduled wide-issue (VLIW) mode. Every instruction carries a 4-bit condition field in its top bits and up to three 4-bit register specifiers: two sources and one destination. The block turns those specifiers into physical register-file addresses.

In wide-issue mode the block also reads the condition field as a bank selector. An explicit "always" code (1111) and the plain "always" code (1110) both make the instruction execute unconditionally. They also steer the general-purpose window, indexes 4 to 12, onto one of two shadow banks. This roughly triples the number of freely usable registers without changing the instruction format.

Argument registers (0–3) and the stack pointer, link register and program counter (13–15) are never redirected. The block also tells the execute stage one of three things: the instruction runs unconditionally, its condition has to be evaluated against the flags, or it is undefined. All outputs are registered, with one cycle of latency.

Top module: `cond_bank_map`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, every output is zero.
- R2: `out_valid` equals `in_valid` from the previous cycle. Every other output likewise reflects the inputs of the previous cycle.
- R3: When `vliw_mode` is 0, each physical address equals its 4-bit index (range 0–15), whatever the condition code.
- R4: When `vliw_mode` is 0 and the condition code is 1111, `undef` is 1 and `run_always`, `need_eval` and `wr_en` are 0.
- R5: When `vliw_mode` is 1 and the condition code is 1111, index i in 4..12 maps to physical address 16 + (i − 4), and `run_always` is 1.
- R6: When `vliw_mode` is 1 and the condition code is 1110, index i in 4..12 maps to physical address 25 + (i − 4), and `run_always` is 1.
- R7: Indexes 0–3 and 13–15 map to themselves in every mode and for every condition code.
- R8: For condition codes 0000–1101, in either mode, every index maps to itself, `need_eval` is 1 and `run_always` is 0.
- R9: At most one of `run_always`, `need_eval` and `undef` is 1. Condition code 1110 gives `run_always` = 1 in both modes. `wr_en` equals `in_valid & dst_we & ~undef` from the previous cycle.
- R10: When `in_valid` is 0, the next `out_valid`, `wr_en`, `run_always`, `need_eval` and `undef` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| vliw_mode | input | 1 | 1 = wide-issue mode, 0 = dynamically scheduled mode |
| cond | input | 4 | Condition field from the top of the instruction |
| src_a | input | 4 | First source register index |
| src_b | input | 4 | Second source register index |
| dst | input | 4 | Destination register index |
| dst_we | input | 1 | The instruction writes its destination |
| out_valid | output | 1 | Registered copy of `in_valid` |
| phys_a | output | 6 | Physical address for `src_a` |
| phys_b | output | 6 | Physical address for `src_b` |
| phys_d | output | 6 | Physical address for `dst` |
| wr_en | output | 1 | Destination write permitted |
| run_always | output | 1 | Execute without consulting the flags |
| need_eval | output | 1 | Condition must be evaluated against the flags |
| undef | output | 1 | Undefined-instruction indication |

## Verification
The bench sweeps both modes, all sixteen condition codes and all sixteen index values on each of the three specifier ports, and compares against addresses worked out arithmetically. The window edges matter most. A design that compares with an off-by-one bound would redirect index 3 or 13, or leave 4 or 12 unmapped. A design with the two shadow banks swapped puts 1111 accesses at 25..33. The bench also targets code 1111 in the dynamically scheduled mode. There, a design that forgets the mode gate would quietly remap registers and let the write through instead of flagging it as undefined. Cycles with `in_valid` low are checked too, so that a stale flag leaking out is caught.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [1:0] {
    BANK_BASE = 2'd0,
    BANK_S0   = 2'd1,
    BANK_S1   = 2'd2
  } bank_t;

  // Condition codes whose meaning the bank steering depends on.
  localparam logic [3:0] COND_AL  = 4'b1110;
  localparam logic [3:0] COND_EXT = 4'b1111;

endpackage

// File: rtl/cbm_cond_decode.sv
module cbm_cond_decode
  import cbm_pkg::*;
(
  input  logic [3:0] cond,
  input  logic       vliw_mode,
  output bank_t      bank,
  output logic       run_always,
  output logic       need_eval,
  output logic       undef
);

  always_comb begin
    bank       = BANK_BASE;
    run_always = 1'b0;
    need_eval  = 1'b0;
    undef      = 1'b0;
    if (cond == COND_EXT) begin
      if (vliw_mode) begin
        run_always = 1'b1;
        bank       = BANK_S0;
      end else begin
        undef = 1'b1;
      end
    end else if (cond == COND_AL) begin
      run_always = 1'b1;
      if (vliw_mode) bank = BANK_S1;
    end else begin
      need_eval = 1'b1;
    end
  end

endmodule

// File: rtl/cbm_idx_remap.sv
module cbm_idx_remap
  import cbm_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int BANK_LO = 4,
  parameter int BANK_HI = 12,
  parameter int PA_W    = 6
) (
  input  bank_t              bank,
  input  logic [IDX_W-1:0]   idx,
  output logic [PA_W-1:0]    paddr
);

  localparam int NREG  = 1 << IDX_W;
  localparam int NBANK = BANK_HI - BANK_LO + 1;
  localparam logic [IDX_W-1:0] LO_I    = IDX_W'(BANK_LO);
  localparam logic [IDX_W-1:0] HI_I    = IDX_W'(BANK_HI);
  localparam logic [PA_W-1:0]  S0_BASE = PA_W'(NREG);
  localparam logic [PA_W-1:0]  S1_BASE = PA_W'(NREG + NBANK);

  logic              in_win;
  logic [IDX_W-1:0]  offset;
  logic [PA_W-1:0]   offset_w;
  logic [PA_W-1:0]   idx_w;

  always_comb begin
    in_win   = (idx >= LO_I) && (idx <= HI_I);
    offset   = idx - LO_I;
    offset_w = PA_W'(offset);
    idx_w    = PA_W'(idx);
    paddr    = idx_w;
    if (in_win) begin
      case (bank)
        BANK_S0: paddr = S0_BASE + offset_w;
        BANK_S1: paddr = S1_BASE + offset_w;
        default: paddr = idx_w;
      endcase
    end
  end

endmodule

// File: rtl/cond_bank_map.sv
module cond_bank_map
  import cbm_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int BANK_LO = 4,
  parameter int BANK_HI = 12,
  localparam int NREG   = 1 << IDX_W,
  localparam int NBANK  = BANK_HI - BANK_LO + 1,
  localparam int PA_W   = $clog2(NREG + 2 * NBANK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             vliw_mode,
  input  logic [3:0]       cond,
  input  logic [IDX_W-1:0] src_a,
  input  logic [IDX_W-1:0] src_b,
  input  logic [IDX_W-1:0] dst,
  input  logic             dst_we,
  output logic             out_valid,
  output logic [PA_W-1:0]  phys_a,
  output logic [PA_W-1:0]  phys_b,
  output logic [PA_W-1:0]  phys_d,
  output logic             wr_en,
  output logic             run_always,
  output logic             need_eval,
  output logic             undef
);

  localparam int NPORT = 3;

  bank_t                       bank;
  logic                        dec_always;
  logic                        dec_eval;
  logic                        dec_undef;
  logic [NPORT-1:0][IDX_W-1:0] idx_vec;
  logic [NPORT-1:0][PA_W-1:0]  pa_vec;

  cbm_cond_decode u_dec (
    .cond       (cond),
    .vliw_mode  (vliw_mode),
    .bank       (bank),
    .run_always (dec_always),
    .need_eval  (dec_eval),
    .undef      (dec_undef)
  );

  assign idx_vec[0] = src_a;
  assign idx_vec[1] = src_b;
  assign idx_vec[2] = dst;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    cbm_idx_remap #(
      .IDX_W   (IDX_W),
      .BANK_LO (BANK_LO),
      .BANK_HI (BANK_HI),
      .PA_W    (PA_W)
    ) u_remap (
      .bank  (bank),
      .idx   (idx_vec[p]),
      .paddr (pa_vec[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      phys_a     <= '0;
      phys_b     <= '0;
      phys_d     <= '0;
      wr_en      <= 1'b0;
      run_always <= 1'b0;
      need_eval  <= 1'b0;
      undef      <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      phys_a     <= pa_vec[0];
      phys_b     <= pa_vec[1];
      phys_d     <= pa_vec[2];
      wr_en      <= in_valid & dst_we & ~dec_undef;
      run_always <= in_valid & dec_always;
      need_eval  <= in_valid & dec_eval;
      undef      <= in_valid & dec_undef;
    end
  end

endmodule

// File: rtl/cond_bank_map_chk.sv
module cond_bank_map_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       vliw_mode,
  input logic [3:0] cond,
  input logic [3:0] dst,
  input logic       dst_we,
  input logic       out_valid,
  input logic [5:0] phys_d,
  input logic       wr_en,
  input logic       run_always,
  input logic       need_eval,
  input logic       undef
);

  logic past_ok;
  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    past_ok <= ~rst;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst_q |-> !out_valid && !wr_en && !undef && !run_always && !need_eval);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> out_valid == $past(in_valid));

  // R4
  undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid && !vliw_mode && cond == 4'hF))
      |-> undef && !wr_en && !run_always);

  // R5
  s0_window_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(vliw_mode && cond == 4'hF && dst >= 4'd4 && dst <= 4'd12))
      |-> phys_d >= 6'd16 && phys_d <= 6'd24);

  // R6
  s1_window_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(vliw_mode && cond == 4'hE && dst >= 4'd4 && dst <= 4'd12))
      |-> phys_d >= 6'd25 && phys_d <= 6'd33);

  // R7
  fixed_regs_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(dst < 4'd4 || dst > 4'd12)) |-> phys_d == {2'b00, $past(dst)});

  // R8
  eval_base_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(in_valid && cond < 4'hE)) |-> need_eval && phys_d == {2'b00, $past(dst)});

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({run_always, need_eval, undef}));

  // R9
  write_gate_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> wr_en == ($past(in_valid && dst_we) && !undef));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!in_valid)) |-> !wr_en && !run_always && !need_eval && !undef);

endmodule

bind cond_bank_map cond_bank_map_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .vliw_mode  (vliw_mode),
  .cond       (cond),
  .dst        (dst),
  .dst_we     (dst_we),
  .out_valid  (out_valid),
  .phys_d     (phys_d),
  .wr_en      (wr_en),
  .run_always (run_always),
  .need_eval  (need_eval),
  .undef      (undef)
);

// File: tb/cond_bank_map_tb.sv
`timescale 1ns/1ps
module cond_bank_map_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic       vliw_mode;
  logic [3:0] cond;
  logic [3:0] src_a;
  logic [3:0] src_b;
  logic [3:0] dst;
  logic       dst_we;
  logic       out_valid;
  logic [5:0] phys_a;
  logic [5:0] phys_b;
  logic [5:0] phys_d;
  logic       wr_en;
  logic       run_always;
  logic       need_eval;
  logic       undef;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cond_bank_map u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vliw_mode(vliw_mode),
    .cond(cond), .src_a(src_a), .src_b(src_b), .dst(dst), .dst_we(dst_we),
    .out_valid(out_valid), .phys_a(phys_a), .phys_b(phys_b), .phys_d(phys_d),
    .wr_en(wr_en), .run_always(run_always), .need_eval(need_eval), .undef(undef)
  );

  function automatic logic [5:0] exp_pa(input logic m, input logic [3:0] c, input logic [3:0] i);
    int v;
    v = int'(i);
    if (m && i >= 4 && i <= 12) begin
      if (c == 4'hF) v = 16 + int'(i) - 4;
      else if (c == 4'hE) v = 25 + int'(i) - 4;
    end
    return 6'(v);
  endfunction

  function automatic string pa_tag(input logic m, input logic [3:0] c, input logic [3:0] i);
    if (i < 4 || i > 12) return "R7";
    if (c < 4'hE) return "R8";
    if (!m) return "R3";
    if (c == 4'hF) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic one(input logic v, input logic m, input logic [3:0] c,
                     input logic [3:0] a, input logic [3:0] b, input logic [3:0] d,
                     input logic we);
    logic e_undef, e_alw, e_eval;
    in_valid = v; vliw_mode = m; cond = c;
    src_a = a; src_b = b; dst = d; dst_we = we;
    @(negedge clk);
    e_undef = v && !m && c == 4'hF;
    e_alw   = v && (c == 4'hE || (m && c == 4'hF));
    e_eval  = v && c < 4'hE;
    check("R2 out_valid", int'(out_valid), int'(v));
    check({pa_tag(m, c, a), " phys_a"}, int'(phys_a), int'(exp_pa(m, c, a)));
    check({pa_tag(m, c, b), " phys_b"}, int'(phys_b), int'(exp_pa(m, c, b)));
    check({pa_tag(m, c, d), " phys_d"}, int'(phys_d), int'(exp_pa(m, c, d)));
    check(v ? "R4 undef" : "R10 undef", int'(undef), int'(e_undef));
    check(v ? "R9 run_always" : "R10 run_always", int'(run_always), int'(e_alw));
    check(v ? "R8 need_eval" : "R10 need_eval", int'(need_eval), int'(e_eval));
    check(v ? "R9 wr_en" : "R10 wr_en", int'(wr_en), int'(v && we && !e_undef));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; vliw_mode = 1'b0; cond = 4'h0;
    src_a = 4'h0; src_b = 4'h0; dst = 4'h0; dst_we = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 phys_d", int'(phys_d), 0);
    check("R1 flags", int'({run_always, need_eval, undef}), 0);
    rst = 1'b0;

    // Exhaustive sweep: R3 R4 R5 R6 R7 R8 R9
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 16; c++)
        for (int i = 0; i < 16; i++)
          one(1'b1, 1'(m), 4'(c), 4'(i), 4'((i + 5) % 16), 4'((i + 11) % 16), 1'(i % 2));

    // Window edges with write enabled: R5 R6 R7
    for (int m = 0; m < 2; m++)
      for (int c = 14; c < 16; c++) begin
        one(1'b1, 1'(m), 4'(c), 4'd3, 4'd4, 4'd12, 1'b1);
        one(1'b1, 1'(m), 4'(c), 4'd13, 4'd12, 4'd4, 1'b1);
      end

    // Idle cycles carry nothing: R10
    for (int c = 0; c < 16; c++)
      one(1'b0, 1'(c % 2), 4'(c), 4'(c), 4'(c), 4'(c), 1'b1);

    // Back-to-back mode flips: R2
    one(1'b1, 1'b1, 4'hF, 4'd7, 4'd8, 4'd9, 1'b1);
    one(1'b1, 1'b0, 4'hF, 4'd7, 4'd8, 4'd9, 1'b1);
    one(1'b1, 1'b1, 4'hE, 4'd7, 4'd8, 4'd9, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule